// File: doc/BRIEF.md
# Sequential Pattern Write Generator for Memory Self-Test

This block fills a region of memory with a known counting pattern so that a separate checker can read it back later. Software or a test sequencer sets three byte quantities: a base address, an end address and a length. It then pulses `start_i`. The generator issues one full-word write per word. The first write goes to the word at the base and carries data 0. Each later write carries the next integer. Writing stops once the requested number of bytes has been covered.

The region from base to end acts as a window whose size in words is a power of two. The write address is the word base plus the word index masked to that window, so a length longer than the window wraps back to the base instead of running past the end. A window of zero size (end equal to base) disables wrapping.

Each write is a command transfer followed by a data transfer, and both are valid/ready channels. The generator raises valid and holds it, with address or data unchanged, until the sink raises ready. The transfer completes on the rising edge where both are high. The sink may hold ready low for any number of cycles. The data channel is never presented until its command transfer has completed. `start_i`, `busy_o` and `done_o` are plain control pins.

Top module: `bist_seq_writer`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `cmd_valid_o` and `wdata_valid_o` are all low.
- R2: The number of writes equals the integer part of the length divided by the word size in bytes (4 bytes by default).
- R3: The first write goes to word address base/4 and carries data 0. Write k carries data k, and with no wrap it goes to word base/4 + k.
- R4: The word address of write k is (base/4 + (k AND (W-1))) modulo the word address range, where W = (end-base)/4 is a power of two.
- R5: When end equals base, no wrapping applies: write k goes to base/4 + k.
- R6: Each write is one command transfer with `cmd_we_o` = 1, followed by exactly one data transfer with `wdata_be_o` all ones. The next command follows only after that data transfer.
- R7: While a channel's valid is high and its ready is low, valid stays high and that channel's address or data stays unchanged.
- R8: `busy_o` is high from the cycle after an accepted start up to and including the `done_o` cycle. `done_o` is a single-cycle pulse in the cycle after the last data transfer.
- R9: A start pulse while `busy_o` is high is ignored: no extra writes occur and the running job is unchanged.
- R10: A length below one word produces no write. `done_o` and `busy_o` are then high in the cycle right after the start.
- R11: Base, end and length are sampled only when a start is accepted; changes during a run do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| base_i | input | 16 | Window base, byte address |
| end_i | input | 16 | Window end, byte address |
| len_i | input | 16 | Bytes to write |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cmd_valid_o | output | 1 | Command channel valid |
| cmd_ready_i | input | 1 | Command channel ready |
| cmd_we_o | output | 1 | Command is a write (always 1) |
| cmd_addr_o | output | 14 | Word address of the command |
| wdata_valid_o | output | 1 | Data channel valid |
| wdata_ready_i | input | 1 | Data channel ready |
| wdata_o | output | 32 | Write data (word index) |
| wdata_be_o | output | 4 | Byte enables (all ones) |

## Verification
The bench targets these corner cases:
- **Wrapping.** Lengths longer than the window, including a one-word window. A design that masked in bytes, or that did not mask at all, would write past the end or to the wrong words.
- **Zero-size window and partial words.** A length that is not a whole number of words must be truncated. A design that rounded up would write one word too many.
- **Back-pressure.** Different stall lengths on the two channels. Dropping valid or changing address or data during a stall would show up as a lost or corrupted write.
- **Start handling.** Zero and sub-word lengths must finish immediately. A start during a run, together with changed configuration inputs, must have no effect. A design that re-armed or resampled would emit extra writes or move the addresses.

// File: rtl/bist_seq_pkg.sv
`timescale 1ns/1ps
package bist_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CMD  = 2'd1,
    ST_DATA = 2'd2,
    ST_FIN  = 2'd3
  } bist_state_e;
endpackage

// File: rtl/bist_cfg_capture.sv
`timescale 1ns/1ps
module bist_cfg_capture #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16,
  parameter int OFF    = 2,
  localparam int WADDR_W = ADDR_W - OFF,
  localparam int CNT_W   = LEN_W - OFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  end_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               req_empty_o,
  output logic [WADDR_W-1:0] base_w_o,
  output logic [WADDR_W-1:0] mask_w_o,
  output logic [CNT_W-1:0]   total_o
);
  logic [WADDR_W-1:0] span_w;

  // Window size in words; a zero span gives an all-ones mask, i.e. no wrap.
  assign span_w      = WADDR_W'((end_i - base_i) >> OFF);
  assign req_empty_o = ((len_i >> OFF) == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_w_o <= '0;
      mask_w_o <= '0;
      total_o  <= '0;
    end else if (load_i) begin
      base_w_o <= WADDR_W'(base_i >> OFF);
      mask_w_o <= span_w - WADDR_W'(1);
      total_o  <= CNT_W'(len_i >> OFF);
    end
  end
endmodule

// File: rtl/bist_word_counter.sv
`timescale 1ns/1ps
module bist_word_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic [CNT_W-1:0] total_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       idx_o <= '0;
    else if (clear_i) idx_o <= '0;
    else if (step_i)  idx_o <= idx_o + CNT_W'(1);
  end

  assign last_o = (idx_o == (total_i - CNT_W'(1)));

  // R2: a data transfer never happens beyond the requested word count
  a_r2_step_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (idx_o < total_i));
endmodule

// File: rtl/bist_addr_map.sv
`timescale 1ns/1ps
module bist_addr_map #(
  parameter int WADDR_W = 14,
  parameter int CNT_W   = 14
) (
  input  logic [WADDR_W-1:0] base_w_i,
  input  logic [WADDR_W-1:0] mask_w_i,
  input  logic [CNT_W-1:0]   idx_i,
  output logic [WADDR_W-1:0] addr_o
);
  logic [WADDR_W-1:0] idx_fit;

  generate
    if (CNT_W >= WADDR_W) begin : g_trunc
      assign idx_fit = idx_i[WADDR_W-1:0];
    end else begin : g_ext
      assign idx_fit = {{(WADDR_W-CNT_W){1'b0}}, idx_i};
    end
  endgenerate

  assign addr_o = base_w_i + (idx_fit & mask_w_i);
endmodule

// File: rtl/bist_write_ctrl.sv
`timescale 1ns/1ps
module bist_write_ctrl
  import bist_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic empty_i,
  input  logic last_i,
  input  logic cmd_ready_i,
  input  logic wdata_ready_i,
  output logic load_o,
  output logic step_o,
  output logic cmd_valid_o,
  output logic wdata_valid_o,
  output logic busy_o,
  output logic done_o
);
  bist_state_e state_q, state_d;

  assign load_o        = (state_q == ST_IDLE) && start_i;
  assign step_o        = (state_q == ST_DATA) && wdata_ready_i;
  assign cmd_valid_o   = (state_q == ST_CMD);
  assign wdata_valid_o = (state_q == ST_DATA);
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)       state_d = empty_i ? ST_FIN : ST_CMD;
      ST_CMD:  if (cmd_ready_i)   state_d = ST_DATA;
      ST_DATA: if (wdata_ready_i) state_d = last_i ? ST_FIN : ST_CMD;
      ST_FIN:                     state_d = ST_IDLE;
      default:                    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R7: valid is held through back-pressure on both channels
  a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> cmd_valid_o);
  a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_valid_o && !wdata_ready_i) |=> wdata_valid_o);
  // R6: a completed command is followed by its data phase
  a_r6_cmd_then_data: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && cmd_ready_i) |=> wdata_valid_o);
  a_r6_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid_o && wdata_valid_o));
  // R8: done is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/bist_seq_writer.sv
`timescale 1ns/1ps
module bist_seq_writer #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16,
  localparam int BE_W    = DATA_W / 8,
  localparam int OFF     = $clog2(BE_W),
  localparam int WADDR_W = ADDR_W - OFF,
  localparam int CNT_W   = LEN_W - OFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  end_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               cmd_valid_o,
  input  logic               cmd_ready_i,
  output logic               cmd_we_o,
  output logic [WADDR_W-1:0] cmd_addr_o,
  output logic               wdata_valid_o,
  input  logic               wdata_ready_i,
  output logic [DATA_W-1:0]  wdata_o,
  output logic [BE_W-1:0]    wdata_be_o
);
  logic               load, step, last, req_empty;
  logic [WADDR_W-1:0] base_w, mask_w;
  logic [CNT_W-1:0]   total, idx;

  bist_cfg_capture #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .OFF(OFF)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .base_i(base_i), .end_i(end_i), .len_i(len_i),
    .req_empty_o(req_empty), .base_w_o(base_w), .mask_w_o(mask_w),
    .total_o(total)
  );

  bist_word_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear_i(load), .step_i(step),
    .total_i(total), .idx_o(idx), .last_o(last)
  );

  bist_addr_map #(.WADDR_W(WADDR_W), .CNT_W(CNT_W)) u_map (
    .base_w_i(base_w), .mask_w_i(mask_w), .idx_i(idx), .addr_o(cmd_addr_o)
  );

  bist_write_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .empty_i(req_empty),
    .last_i(last), .cmd_ready_i(cmd_ready_i), .wdata_ready_i(wdata_ready_i),
    .load_o(load), .step_o(step), .cmd_valid_o(cmd_valid_o),
    .wdata_valid_o(wdata_valid_o), .busy_o(busy_o), .done_o(done_o)
  );

  assign cmd_we_o   = 1'b1;
  assign wdata_o    = DATA_W'(idx);
  assign wdata_be_o = '1;

  // R7: payload stays stable while the sink stalls
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> $stable(cmd_addr_o));
  a_r7_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_valid_o && !wdata_ready_i) |=> $stable(wdata_o));
  // R3: data advances by exactly one per completed data transfer
  a_r3_data_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wdata_valid_o && wdata_ready_i && !done_o) |=>
      (!wdata_valid_o && (wdata_o == $past(wdata_o) + DATA_W'(1))));
  // R9: no configuration reload while a job is running
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(base_w) && $stable(mask_w) && $stable(total)));
endmodule

// File: tb/bist_seq_writer_tb_top.sv
`timescale 1ns/1ps
module bist_seq_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] base_i = '0, end_i = '0, len_i = '0;
  logic        busy_o, done_o, cmd_valid_o, cmd_we_o, wdata_valid_o;
  logic        cmd_ready_i = 1'b0, wdata_ready_i = 1'b0;
  logic [13:0] cmd_addr_o;
  logic [31:0] wdata_o;
  logic [3:0]  wdata_be_o;

  int checks = 0, fails = 0;
  int widx = 0;
  int stall_c = 0, stall_d = 0, cwait = 0, dwait = 0;
  logic [15:0] exp_base = '0, exp_end = '0;
  logic pv_cmd = 0, pv_dat = 0, cmd_pend = 0, pwe = 0;
  logic [13:0] pa_cmd = '0;
  logic [31:0] pd = '0;
  logic [3:0]  pbe = '0;

  always #4 clk = ~clk;

  bist_seq_writer dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .end_i(end_i),
    .len_i(len_i), .busy_o(busy_o), .done_o(done_o), .cmd_valid_o(cmd_valid_o),
    .cmd_ready_i(cmd_ready_i), .cmd_we_o(cmd_we_o), .cmd_addr_o(cmd_addr_o),
    .wdata_valid_o(wdata_valid_o), .wdata_ready_i(wdata_ready_i), .wdata_o(wdata_o),
    .wdata_be_o(wdata_be_o)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [13:0] exp_addr(input int k);
    logic [13:0] bw, win, msk;
    bw  = exp_base[15:2];
    win = 14'((exp_end - exp_base) >> 2);
    msk = win - 14'd1;
    return bw + (14'(k) & msk);
  endfunction

  // Sink model and per-transfer monitor, on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      pv_cmd <= 0; pv_dat <= 0; cmd_pend <= 0;
      cmd_ready_i <= 0; wdata_ready_i <= 0; cwait <= 0; dwait <= 0;
    end else begin
      if (pv_cmd && cmd_ready_i) begin
        chk(!cmd_pend && pwe, "R6 command order/we", {cmd_pend, pwe}, 2'b01);
        chk(pa_cmd == exp_addr(widx), "R3/R4/R5 address", pa_cmd, exp_addr(widx));
        cmd_pend = 1;
      end
      if (pv_dat && wdata_ready_i) begin
        chk(cmd_pend && pbe == 4'hF, "R6 data after command, all byte enables", {cmd_pend, pbe}, 5'h1F);
        chk(pd == 32'(widx), "R3 data", pd, widx);
        cmd_pend = 0;
        widx = widx + 1;
      end
      if (pv_cmd && !cmd_ready_i)
        chk(cmd_valid_o && cmd_addr_o == pa_cmd, "R7 cmd hold", cmd_addr_o, pa_cmd);
      if (pv_dat && !wdata_ready_i)
        chk(wdata_valid_o && wdata_o == pd, "R7 data hold", wdata_o, pd);
      pv_cmd <= cmd_valid_o; pa_cmd <= cmd_addr_o; pwe <= cmd_we_o;
      pv_dat <= wdata_valid_o; pd <= wdata_o; pbe <= wdata_be_o;
      if (cmd_ready_i) cmd_ready_i <= 0;
      else if (cmd_valid_o) begin
        if (cwait >= stall_c) begin cmd_ready_i <= 1; cwait <= 0; end
        else cwait <= cwait + 1;
      end
      if (wdata_ready_i) wdata_ready_i <= 0;
      else if (wdata_valid_o) begin
        if (dwait >= stall_d) begin wdata_ready_i <= 1; dwait <= 0; end
        else dwait <= dwait + 1;
      end
    end
  end

  // Runs one job; optionally pokes a second start and new inputs mid-run (R9, R11)
  task automatic run_job(input logic [15:0] b, input logic [15:0] e, input logic [15:0] l,
                         input int sc, input int sd, input bit poke);
    int words, cyc;
    bit seen, busy_ok;
    words = int'(l) / 4;
    @(negedge clk); #1;
    exp_base = b; exp_end = e; widx = 0; stall_c = sc; stall_d = sd;
    base_i = b; end_i = e; len_i = l; start_i = 1;
    @(negedge clk); #1;
    start_i = 0;
    seen = 0; busy_ok = 1; cyc = 0;
    while (!seen && cyc < 3000) begin
      if (!busy_o) busy_ok = 0;
      if (done_o) seen = 1;
      else begin
        if (poke && cyc == 4) begin
          start_i = 1; base_i = 16'h0200; end_i = 16'h0400; len_i = 16'd8;
        end else if (poke && cyc == 5) start_i = 0;
        @(negedge clk); #1;
        cyc++;
      end
    end
    chk(seen, "R8 done reached", seen, 1);
    chk(busy_ok, "R8 busy while running", busy_ok, 1);
    chk(widx == words, "R2/R9 write count", widx, words);
    @(negedge clk); #1;
    chk(!done_o && !busy_o, "R8 single-cycle done", {done_o, busy_o}, 0);
  endtask

  localparam logic [55:0] VEC [6] = '{
    {16'h0010, 16'h0030, 16'd20, 4'd0, 4'd0},  // 5 words, no wrap
    {16'h0040, 16'h0050, 16'd40, 4'd2, 4'd1},  // 10 words into 4-word window
    {16'h0008, 16'h0008, 16'd16, 4'd1, 4'd3},  // zero window: no wrap
    {16'h0100, 16'h0104, 16'd12, 4'd0, 4'd2},  // 1-word window
    {16'h0020, 16'h0060, 16'd22, 4'd3, 4'd0},  // partial word truncated
    {16'h0000, 16'h0040, 16'd64, 4'd0, 4'd0}   // exactly fills window
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !cmd_valid_o && !wdata_valid_o, "R1 reset state",
        {busy_o, done_o, cmd_valid_o, wdata_valid_o}, 0);
    #1 rst_n = 1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !cmd_valid_o, "R1 idle after reset", {busy_o, cmd_valid_o}, 0);

    // Vector table: R2, R3, R4, R5, R6, R7, R8
    for (int i = 0; i < 6; i++)
      run_job(VEC[i][55:40], VEC[i][39:24], VEC[i][23:8], int'(VEC[i][7:4]), int'(VEC[i][3:0]), 0);

    // R9 and R11: restart and changed inputs during a run are ignored
    run_job(16'h0010, 16'h0020, 16'd24, 1, 1, 1);
    repeat (6) begin
      @(negedge clk); #1;
      chk(!busy_o && !cmd_valid_o, "R9 no second job", {busy_o, cmd_valid_o}, 0);
    end
    chk(widx == 6, "R11 first config kept", widx, 6);

    // R10: sub-word and zero lengths
    for (int l = 0; l < 4; l += 3) begin
      @(negedge clk); #1;
      widx = 0; base_i = 16'h0030; end_i = 16'h0040; len_i = 16'(l); start_i = 1;
      @(negedge clk); #1;
      start_i = 0;
      chk(done_o && busy_o && !cmd_valid_o, "R10 immediate done", {done_o, busy_o, cmd_valid_o}, 3'b110);
      @(negedge clk); #1;
      chk(!done_o && !busy_o && widx == 0, "R10 no writes", widx, 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule